// File: doc/BRIEF.md
# Execution Trace Status and Data Port

This block turns per-cycle execution events from a processor core into a compact real-time trace stream for an external analyzer. Each cycle it drives a 4-bit status code, which says whether an instruction began, continued, branched, returned from an exception, entered user mode or executed a pulse/write-data instruction. It also drives a 4-bit data nibble bus that carries captured payloads: branch target addresses and operands written out by the core.

Payloads enter a two-entry buffer. Before its nibbles appear, each payload is announced on the status bus by a length code, one cycle ahead of its first nibble. The nibbles then follow, least significant first. The buffer asks the core to stall when it can accept no more. A one-deep holding register keeps status codes in order when a length code takes the status bus.

Top module: `trace_port`

## Requirements
- R1: Event kinds on `ev_kind_i` map to status codes on `pst_o` one cycle after the event is accepted. The kinds are 0 none, 1 continue, 2 begin, 3 user-mode entry, 4 pulse, 5 write-data, 6 taken branch and 7 exception return. They give codes 0x0, 0x1, 0x3, 0x4, 0x4, 0x5 and 0x7, in that order of kinds from continue to exception return. Kind 0 gives no code.
- R2: `pst_o` never carries 0x2 or 0x6.
- R3: A payload of N bytes, where N is 1 to 4, is announced by the length code 0x8+N-1 on `pst_o`. For write-data, `wd_size_i` sets N: 0 gives 1, 1 gives 2, and 2 or 3 give 4. For a taken branch, N is `br_bytes_i`, with values above 4 treated as 4. When `br_bytes_i` is 0 there is no payload and no length code.
- R4: For a write-data event, the code 0x4 is followed on the next cycle by the length code. The first data nibble appears on `ddata_o` exactly one cycle after the length code.
- R5: A payload is shown on `ddata_o` as 2N consecutive nibbles, least significant first. Bits above byte N are never shown.
- R6: When no nibble is being shown, `ddata_o` is 0x0. When no status or length code is due, `pst_o` is 0x0.
- R7: The length code of the next buffered payload is driven in the cycle of the current payload's last nibble. Consecutive payloads therefore leave no idle gap on `ddata_o`.
- R8: `stall_o` is high while both buffer entries are occupied. It falls in the cycle after an entry is released. An event presented while `stall_o` is high is ignored.
- R9: A length code has priority over a status code on `pst_o`. The displaced status code is kept in a one-deep holding register and shown in the next cycle without a length code, with the order of status codes preserved.
- R10: `stall_o` is also high in a cycle where a status code is held and a length code is due, because a new status code could not be stored.
- R11: An asynchronous active-low reset empties the buffer and the holding register. It drives 0x0 on `pst_o` and `ddata_o` and clears `stall_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_kind_i | input | 3 | Execution event kind of this cycle (0 = none) |
| wd_size_i | input | 2 | Operand size of a write-data event |
| br_bytes_i | input | 3 | Configured number of target-address bytes for taken branches |
| payload_i | input | 32 | Branch target or written operand |
| pst_o | output | 4 | Status or length code |
| ddata_o | output | 4 | Payload nibble |
| stall_o | output | 1 | Core must hold its next event |

## Verification
The hardest case to reach is the stall caused by a held status code meeting a due length code, while the buffer is not full. It needs a displaced status, then a fresh status in the following cycle, and that cycle must be the last nibble of a short payload. The bench gets there with two back-to-back one-byte write-data events followed by an ordinary instruction start. A second directed sequence sends three longword write-data events back to back, then offers an event during the full-buffer stall. This covers the no-gap handover and the dropped event.

// File: rtl/trace_pkg.sv
`timescale 1ns/1ps
package trace_pkg;
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned PAY_BYTES = 4;
  localparam int unsigned PAY_W     = PAY_BYTES * 8;
  localparam int unsigned LEN_W     = $clog2(PAY_BYTES + 1);
  localparam int unsigned NCNT_W    = $clog2(2 * PAY_BYTES + 1);

  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_CONT   = 3'd1,
    EV_BEGIN  = 3'd2,
    EV_USER   = 3'd3,
    EV_PULSE  = 3'd4,
    EV_WDATA  = 3'd5,
    EV_BRANCH = 3'd6,
    EV_RTE    = 3'd7
  } ev_kind_e;

  localparam logic [3:0] PST_CONT   = 4'h0;
  localparam logic [3:0] PST_BEGIN  = 4'h1;
  localparam logic [3:0] PST_USER   = 4'h3;
  localparam logic [3:0] PST_PULSE  = 4'h4;
  localparam logic [3:0] PST_BRANCH = 4'h5;
  localparam logic [3:0] PST_RTE    = 4'h7;
  localparam logic [3:0] PST_MARK   = 4'h8;

  typedef struct packed {
    logic [LEN_W-1:0] nbytes;
    logic [PAY_W-1:0] data;
  } pay_t;

  function automatic logic [3:0] status_of(ev_kind_e k);
    case (k)
      EV_BEGIN:           return PST_BEGIN;
      EV_USER:            return PST_USER;
      EV_PULSE, EV_WDATA: return PST_PULSE;
      EV_BRANCH:          return PST_BRANCH;
      EV_RTE:             return PST_RTE;
      default:            return PST_CONT;
    endcase
  endfunction
endpackage

// File: rtl/trace_evt_dec.sv
`timescale 1ns/1ps
module trace_evt_dec
  import trace_pkg::*;
(
  input  ev_kind_e         kind_i,
  input  logic [1:0]       wd_size_i,
  input  logic [LEN_W-1:0] br_bytes_i,
  input  logic [PAY_W-1:0] data_i,
  input  logic             accept_i,
  output logic             stat_v_o,
  output logic [3:0]       stat_o,
  output logic             push_o,
  output pay_t             pay_o
);
  localparam logic [LEN_W-1:0] MAXB = LEN_W'(PAY_BYTES);

  logic [LEN_W-1:0] wd_len, br_len, len;

  always_comb begin
    case (wd_size_i)
      2'd0:    wd_len = LEN_W'(1);
      2'd1:    wd_len = LEN_W'(2);
      default: wd_len = MAXB;
    endcase
    br_len = (br_bytes_i > MAXB) ? MAXB : br_bytes_i;
    case (kind_i)
      EV_WDATA:  len = wd_len;
      EV_BRANCH: len = br_len;
      default:   len = '0;
    endcase
  end

  assign stat_v_o    = accept_i && (kind_i != EV_NONE);
  assign stat_o      = status_of(kind_i);
  assign push_o      = accept_i && (len != '0);
  assign pay_o.nbytes = len;
  assign pay_o.data   = data_i;
endmodule

// File: rtl/trace_fifo.sv
`timescale 1ns/1ps
module trace_fifo
  import trace_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  pay_t             din_i,
  output pay_t             dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  pay_t             mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] inc(logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= inc(wr_q);
      if (pop_i)  rd_q <= inc(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && wr_q == PTR_W'(g)) mem[g] <= din_i;
    end
  end

  assign dout_o  = mem[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/trace_shifter.sv
`timescale 1ns/1ps
module trace_shifter
  import trace_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  pay_t             pay_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [NIB_W-1:0] nib_o
);
  logic [NCNT_W-1:0] left_q;
  logic [PAY_W-1:0]  sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      sh_q   <= '0;
    end else if (load_i) begin
      left_q <= NCNT_W'({pay_i.nbytes, 1'b0});
      sh_q   <= pay_i.data;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      sh_q   <= sh_q >> NIB_W;
    end
  end

  assign busy_o = (left_q != '0);
  assign last_o = (left_q == NCNT_W'(1));
  assign nib_o  = sh_q[NIB_W-1:0];
endmodule

// File: rtl/trace_pst_arb.sv
`timescale 1ns/1ps
module trace_pst_arb (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mark_req_i,
  input  logic [3:0] mark_code_i,
  input  logic       stat_v_i,
  input  logic [3:0] stat_i,
  output logic [3:0] pst_nxt_o,
  output logic       hold_v_o
);
  logic       hold_v_q, hold_v_d;
  logic [3:0] hold_q, hold_d;

  // marker > held status > fresh status; stall keeps a fresh one from
  // arriving while held and marker collide
  always_comb begin
    hold_v_d  = hold_v_q;
    hold_d    = hold_q;
    pst_nxt_o = 4'h0;
    if (mark_req_i) begin
      pst_nxt_o = mark_code_i;
      if (stat_v_i) begin
        hold_v_d = 1'b1;
        hold_d   = stat_i;
      end
    end else if (hold_v_q) begin
      pst_nxt_o = hold_q;
      hold_v_d  = stat_v_i;
      hold_d    = stat_i;
    end else if (stat_v_i) begin
      pst_nxt_o = stat_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q <= 1'b0;
      hold_q   <= 4'h0;
    end else begin
      hold_v_q <= hold_v_d;
      hold_q   <= hold_d;
    end
  end

  assign hold_v_o = hold_v_q;
endmodule

// File: rtl/trace_port.sv
`timescale 1ns/1ps
module trace_port
  import trace_pkg::*;
#(
  parameter int unsigned BUF_DEPTH = 2,
  localparam int unsigned CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       ev_kind_i,
  input  logic [1:0]       wd_size_i,
  input  logic [LEN_W-1:0] br_bytes_i,
  input  logic [PAY_W-1:0] payload_i,
  output logic [3:0]       pst_o,
  output logic [NIB_W-1:0] ddata_o,
  output logic             stall_o
);
  ev_kind_e         kind;
  logic             accept, stat_v, push, pop;
  logic [3:0]       stat_code, mark_code, pst_nxt;
  pay_t             pay_in, head;
  logic             fifo_empty, fifo_full;
  logic [CNT_W-1:0] fifo_cnt;
  logic             sh_busy, sh_last, mark_req, hold_v;
  logic [NIB_W-1:0] sh_nib;
  logic [3:0]       pst_q;
  logic [NIB_W-1:0] dd_q;
  logic             dd_act;

  assign kind     = ev_kind_e'(ev_kind_i);
  assign mark_req = !fifo_empty && (!sh_busy || sh_last);
  assign pop      = mark_req;
  assign stall_o  = fifo_full || (hold_v && mark_req);
  assign accept   = (kind != EV_NONE) && !stall_o;
  assign mark_code = PST_MARK + 4'(head.nbytes) - 4'd1;

  trace_evt_dec u_dec (
    .kind_i     (kind),
    .wd_size_i  (wd_size_i),
    .br_bytes_i (br_bytes_i),
    .data_i     (payload_i),
    .accept_i   (accept),
    .stat_v_o   (stat_v),
    .stat_o     (stat_code),
    .push_o     (push),
    .pay_o      (pay_in)
  );

  trace_fifo #(.DEPTH(BUF_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (pay_in),
    .dout_o  (head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .cnt_o   (fifo_cnt)
  );

  trace_shifter u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pop),
    .pay_i  (head),
    .busy_o (sh_busy),
    .last_o (sh_last),
    .nib_o  (sh_nib)
  );

  trace_pst_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mark_req_i  (mark_req),
    .mark_code_i (mark_code),
    .stat_v_i    (stat_v),
    .stat_i      (stat_code),
    .pst_nxt_o   (pst_nxt),
    .hold_v_o    (hold_v)
  );

  // outputs registered; shifter load and marker share an edge, so the
  // extra data stage yields the one-cycle marker lead
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pst_q  <= 4'h0;
      dd_q   <= '0;
      dd_act <= 1'b0;
    end else begin
      pst_q  <= pst_nxt;
      dd_q   <= sh_busy ? sh_nib : '0;
      dd_act <= sh_busy;
    end
  end

  assign pst_o   = pst_q;
  assign ddata_o = dd_q;
endmodule

// File: rtl/trace_port_chk.sv
`timescale 1ns/1ps
module trace_port_chk #(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       pst_o,
  input logic [3:0]       ddata_o,
  input logic             stall_o,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             hold_v,
  input logic             mark_req,
  input logic             push,
  input logic             dd_act
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  // R2
  rsvd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pst_o != 4'h2) && (pst_o != 4'h6));

  // R4
  mark_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pst_o[3] |=> dd_act);

  // R4
  first_nib_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dd_act) |-> $past(pst_o[3]));

  // R6
  dd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dd_act |-> (ddata_o == 4'h0));

  // R8
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_cnt == FULL_CNT) |-> stall_o);

  // R8
  push_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> (fifo_cnt != FULL_CNT));

  // R10
  stall_why_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ((fifo_cnt == FULL_CNT) || (hold_v && mark_req)));

  // R9
  hold_show_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_v && !mark_req) |=> !pst_o[3]);
endmodule

bind trace_port trace_port_chk #(.DEPTH(BUF_DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pst_o    (pst_o),
  .ddata_o  (ddata_o),
  .stall_o  (stall_o),
  .fifo_cnt (fifo_cnt),
  .hold_v   (hold_v),
  .mark_req (mark_req),
  .push     (push),
  .dd_act   (dd_act)
);

// File: tb/tb_trace_port.sv
`timescale 1ns/1ps
module tb_trace_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  ev_kind_i = 3'd0;
  logic [1:0]  wd_size_i = 2'd0;
  logic [2:0]  br_bytes_i = 3'd0;
  logic [31:0] payload_i = '0;
  logic [3:0]  pst_o, ddata_o;
  logic        stall_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  trace_port dut (.*);

  typedef struct packed {
    logic [2:0]  k;
    logic [1:0]  w;
    logic [2:0]  b;
    logic [31:0] d;
    logic [3:0]  code;
    logic [2:0]  nb;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{3'd1, 2'd0, 3'd0, 32'h0,        4'h0, 3'd0},
    '{3'd2, 2'd0, 3'd0, 32'h0,        4'h1, 3'd0},
    '{3'd3, 2'd0, 3'd0, 32'h0,        4'h3, 3'd0},
    '{3'd4, 2'd0, 3'd0, 32'h0,        4'h4, 3'd0},
    '{3'd7, 2'd0, 3'd0, 32'h0,        4'h7, 3'd0},
    '{3'd5, 2'd0, 3'd0, 32'h123456A5, 4'h4, 3'd1},
    '{3'd5, 2'd1, 3'd0, 32'hFFFF1234, 4'h4, 3'd2},
    '{3'd5, 2'd2, 3'd0, 32'hDEADBEEF, 4'h4, 3'd4},
    '{3'd5, 2'd3, 3'd0, 32'h13579BDF, 4'h4, 3'd4},
    '{3'd6, 2'd0, 3'd0, 32'h89ABCDEF, 4'h5, 3'd0},
    '{3'd6, 2'd0, 3'd3, 32'h77ABCDEF, 4'h5, 3'd3},
    '{3'd6, 2'd0, 3'd4, 32'h89ABCDEF, 4'h5, 3'd4},
    '{3'd6, 2'd0, 3'd7, 32'h2468ACE0, 4'h5, 3'd4}
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic drive(logic [2:0] k, logic [1:0] w, logic [2:0] b, logic [31:0] d);
    ev_kind_i = k; wd_size_i = w; br_bytes_i = b; payload_i = d;
  endtask

  task automatic idle(int n);
    drive(3'd0, 2'd0, 3'd0, 32'h0);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [3:0] nib(logic [31:0] d, int i);
    return 4'((d >> (4 * i)) & 32'hF);
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 outputs during reset
    chk("R11 pst in reset", pst_o, 0);
    chk("R11 ddata in reset", ddata_o, 0);
    chk("R11 stall in reset", stall_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table walk: R1 status, R3 marker, R4 order, R5 nibbles, R6 idle
    for (int v = 0; v < NV; v++) begin
      drive(TBL[v].k, TBL[v].w, TBL[v].b, TBL[v].d);
      @(negedge clk_i);
      drive(3'd0, 2'd0, 3'd0, 32'h0);
      chk("R1 status code", pst_o, TBL[v].code);
      chk("R8 no stall single", stall_o, 0);
      if (TBL[v].nb != 0) begin
        @(negedge clk_i);
        chk("R3 length code after status", pst_o, 32'h8 + TBL[v].nb - 1);
        chk("R4 no data with marker", ddata_o, 0);
        for (int i = 0; i < 2 * TBL[v].nb; i++) begin
          @(negedge clk_i);
          chk("R5 nibble lsb first", ddata_o, nib(TBL[v].d, i));
          chk("R6 pst quiet during data", pst_o, 0);
        end
      end
      @(negedge clk_i);
      chk("R6 ddata idle", ddata_o, 0);
      chk("R6 pst idle", pst_o, 0);
      idle(2);
    end

    // back-to-back longwords: R7 gapless, R8 full stall, ignored event, R9 hold
    begin
      logic [31:0] d1, d2, d3;
      d1 = 32'h76543210; d2 = 32'hFEDCBA98; d3 = 32'h0F1E2D3C;
      for (int k = 0; k <= 29; k++) begin
        logic [3:0] ep, ed;
        logic       es;
        if (k > 0) begin
          ep = (k == 1 || k == 3 || k == 4) ? 4'h4 :
               (k == 2 || k == 10 || k == 18) ? 4'hB : 4'h0;
          es = (k >= 3 && k <= 9);
          if (k >= 3 && k <= 10)       ed = nib(d1, k - 3);
          else if (k >= 11 && k <= 18) ed = nib(d2, k - 11);
          else if (k >= 19 && k <= 26) ed = nib(d3, k - 19);
          else                         ed = 4'h0;
          if (k == 10 || k == 18) chk("R7 marker on last nibble", pst_o, ep);
          else if (k == 3 || k == 4) chk("R9 held status order", pst_o, ep);
          else if (k == 5) chk("R8 event in stall ignored", pst_o, ep);
          else chk("R1 pst sequence", pst_o, ep);
          chk("R7 gapless ddata", ddata_o, ed);
          chk("R8 stall on full buffer", stall_o, es);
        end
        case (k)
          0, 1, 2: drive(3'd5, 2'd2, 3'd0, k == 0 ? d1 : (k == 1 ? d2 : d3));
          3:       drive(3'd7, 2'd0, 3'd0, 32'h0);
          default: drive(3'd0, 2'd0, 3'd0, 32'h0);
        endcase
        @(negedge clk_i);
      end
    end
    idle(3);

    // held status meets due marker: R10 stall, R9 priority
    for (int k = 0; k <= 8; k++) begin
      logic [3:0] ep, ed;
      if (k > 0) begin
        case (k)
          1, 3:    ep = 4'h4;
          2, 4:    ep = 4'h8;
          5:       ep = 4'h1;
          default: ep = 4'h0;
        endcase
        case (k)
          3:       ed = 4'hA;
          4:       ed = 4'h5;
          5:       ed = 4'h3;
          6:       ed = 4'hC;
          default: ed = 4'h0;
        endcase
        chk("R9 marker wins over status", pst_o, ep);
        chk("R5 short payload nibbles", ddata_o, ed);
        chk("R10 stall on hold conflict", stall_o, k == 3);
      end
      case (k)
        0:       drive(3'd5, 2'd0, 3'd0, 32'h5A);
        1:       drive(3'd5, 2'd0, 3'd0, 32'hC3);
        2:       drive(3'd2, 2'd0, 3'd0, 32'h0);
        default: drive(3'd0, 2'd0, 3'd0, 32'h0);
      endcase
      @(negedge clk_i);
    end
    idle(3);

    // mid-run reset: R11
    drive(3'd5, 2'd2, 3'd0, 32'hAAAA5555);
    @(negedge clk_i);
    drive(3'd5, 2'd2, 3'd0, 32'h5555AAAA);
    @(negedge clk_i);
    drive(3'd5, 2'd2, 3'd0, 32'h12345678);
    @(negedge clk_i);
    drive(3'd0, 2'd0, 3'd0, 32'h0);
    @(negedge clk_i);
    chk("R8 stall before reset", stall_o, 1);
    rst_ni = 1'b0;
    #1;
    chk("R11 pst cleared", pst_o, 0);
    chk("R11 ddata cleared", ddata_o, 0);
    chk("R11 stall cleared", stall_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      chk("R11 buffer emptied ddata", ddata_o, 0);
      chk("R11 buffer emptied pst", pst_o, 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule